// File: doc/BRIEF.md
# Oversampled Channelizer Frame Builder

This block assembles the input frames of an oversampling polyphase channelizer, where the channel count K exceeds the decimation M. Fresh samples arrive on a valid/ready stream and wait in a small FIFO. The block gathers exactly M of them into a K-deep sample history and then emits one frame of K samples. So every frame shares K-M samples with the one before it. With M equal to K the frames are disjoint. With M equal to K/2, half of each frame is reused.

Each frame is emitted circularly rotated by (m*M) mod K, where m is the frame number. A rotation of the FFT input is the same as the per-bin phase factor that an oversampled channelizer would otherwise apply after the FFT, so no complex multiplier is needed downstream. A frame leaves as K consecutive beats. Each beat carries its frame tag and its sample index. The polyphase filter and the FFT sit outside this block.

Control is a two-state machine. In `ST_GATHER` the block pops one FIFO word per cycle into the history. On the M-th pop it takes transition *gather_done* to `ST_EMIT`. In `ST_EMIT` it issues one beat per cycle and, after beat K-1, takes transition *frame_done* back to `ST_GATHER`. At *frame_done* the rotation advances by M modulo K and the frame tag increments.

Top module: `ovl_frame_builder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, the frame tag and rotation are 0, and every history entry reads as zero.
- R2: Frame m is emitted only after (m+1)*M samples have been accepted in total.
- R3: The window of frame m is the K most recent accepted samples, oldest first. Window position j holds accepted sample number (m+1)*M-K+j (counting from 0), or zero if that number is negative.
- R4: Beat i of frame m carries window position (i + (m*M mod K)) mod K.
- R5: When M equals K, frames do not overlap and beat i of frame m carries accepted sample m*K+i unrotated.
- R6: A frame is K beats on consecutive cycles with `out_index` 0, 1, ..., K-1 and a constant `out_frame`; the cycle after beat K-1 has `out_valid` low.
- R7: `out_frame` increments by one per frame and wraps modulo 2^FRAME_W.
- R8: `in_ready` is low only while the FIFO holds FIFO_DEPTH words; no accepted sample is lost or reordered.
- R9: Gaps in `in_valid` only delay frames and never change their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_data | input | DATA_W | Input sample |
| in_ready | output | 1 | FIFO can accept a sample |
| out_valid | output | 1 | Output beat present |
| out_data | output | DATA_W | Rotated frame sample |
| out_frame | output | FRAME_W | Frame tag, wraps |
| out_index | output | log2(K) | Sample index inside the frame |

## Verification
The main instance uses K=8 and M=6. Because 6 does not divide 8, the rotation steps through 0, 6, 4, 2 and the first frame still contains two zero-filled positions. FIFO_DEPTH=4 is shorter than the eight-beat emission, so continuous input is forced to stall on `in_ready`. FRAME_W=4 makes the tag wrap within eighteen frames. A second instance with M=K=8 runs on a free-running stream and covers the disjoint, unrotated case.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [0:0] {
        ST_GATHER = 1'b0,
        ST_EMIT   = 1'b1
    } ovl_state_t;

endpackage

// File: rtl/ovl_fifo.sv
module ovl_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          pop_data,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [DATA_W-1:0] store [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    assign pop_data = store[rd_ptr];

endmodule

// File: rtl/ovl_history.sv
module ovl_history #(
    parameter int DATA_W = 16,
    parameter int K      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [$clog2(K)-1:0]    rd_offset,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int IW = $clog2(K);

    logic [DATA_W-1:0] hist [K];
    logic [IW-1:0]     oldest;
    logic [IW-1:0]     rd_addr;

    // oldest points at the slot written next, which is the oldest entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oldest <= '0;
            for (int e = 0; e < K; e++) begin
                hist[e] <= '0;
            end
        end else if (wr_en) begin
            hist[oldest] <= wr_data;
            oldest       <= oldest + 1'b1;
        end
    end

    assign rd_addr = oldest + rd_offset;
    assign rd_data = hist[rd_addr];

endmodule

// File: rtl/ovl_rotator.sv
module ovl_rotator #(
    parameter int K       = 16,
    parameter int M       = 12,
    parameter int FRAME_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    advance,
    output logic [$clog2(K)-1:0]    shift,
    output logic [FRAME_W-1:0]      frame
);
    localparam int IW = $clog2(K);
    localparam logic [IW-1:0] STEP = IW'(M % K);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift <= '0;
            frame <= '0;
        end else if (advance) begin
            shift <= shift + STEP;
            frame <= frame + 1'b1;
        end
    end

endmodule

// File: rtl/ovl_frame_builder.sv
module ovl_frame_builder #(
    parameter int DATA_W     = 16,
    parameter int K          = 16,
    parameter int M          = 12,
    parameter int FIFO_DEPTH = 4,
    parameter int FRAME_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_data,
    output logic [FRAME_W-1:0]      out_frame,
    output logic [$clog2(K)-1:0]    out_index
);
    import ovl_pkg::*;

    localparam int IW = $clog2(K);
    localparam int CW = $clog2(M + 1);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;

    ovl_state_t        state;
    ovl_state_t        state_nxt;
    logic [IW-1:0]     beat;
    logic [CW-1:0]     gathered;
    logic [LW-1:0]     fifo_level;
    logic [DATA_W-1:0] fifo_q;
    logic [DATA_W-1:0] hist_q;
    logic [IW-1:0]     shift;
    logic [FRAME_W-1:0] frame;
    logic              push;
    logic              pop;
    logic              last_pop;
    logic              last_beat;

    assign in_ready  = (fifo_level != LW'(FIFO_DEPTH));
    assign push      = in_valid && in_ready;
    assign pop       = (state == ST_GATHER) && (fifo_level != '0);
    assign last_pop  = pop && (gathered == CW'(M - 1));
    assign last_beat = (state == ST_EMIT) && (beat == IW'(K - 1));

    ovl_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (in_data),
        .pop       (pop),
        .pop_data  (fifo_q),
        .level     (fifo_level)
    );

    ovl_history #(
        .DATA_W (DATA_W),
        .K      (K)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (pop),
        .wr_data   (fifo_q),
        .rd_offset (beat + shift),
        .rd_data   (hist_q)
    );

    ovl_rotator #(
        .K       (K),
        .M       (M),
        .FRAME_W (FRAME_W)
    ) u_rot (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (last_beat),
        .shift   (shift),
        .frame   (frame)
    );

    // transitions: gather_done (M-th pop), frame_done (beat K-1 issued)
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_GATHER: if (last_pop)  state_nxt = ST_EMIT;
            ST_EMIT:   if (last_beat) state_nxt = ST_GATHER;
        endcase
    end

    // state register with its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_GATHER;
            beat     <= '0;
            gathered <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_GATHER && pop) begin
                gathered <= last_pop ? '0 : gathered + 1'b1;
            end
            if (state == ST_EMIT) begin
                beat <= last_beat ? '0 : beat + 1'b1;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_frame <= '0;
            out_index <= '0;
        end else begin
            out_valid <= (state == ST_EMIT);
            out_data  <= hist_q;
            out_frame <= frame;
            out_index <= beat;
        end
    end

endmodule

// File: rtl/ovl_frame_builder_chk.sv
module ovl_frame_builder_chk #(
    parameter int K          = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int FRAME_W    = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_ready,
    input logic                         out_valid,
    input logic [FRAME_W-1:0]           out_frame,
    input logic [$clog2(K)-1:0]         out_index,
    input logic [$clog2(FIFO_DEPTH):0]  fifo_level
);
    localparam int IW = $clog2(K);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;

    logic [FRAME_W-1:0] prev_tag;
    logic               tag_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tag <= '0;
            tag_seen <= 1'b0;
        end else if (out_valid && out_index == IW'(K - 1)) begin
            prev_tag <= out_frame;
            tag_seen <= 1'b1;
        end
    end

    a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_index != IW'(K - 1) |=> out_valid && out_index == $past(out_index) + 1'b1);

    a_r6_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_index == IW'(K - 1) |=> !out_valid);

    a_r6_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_index == '0);

    a_r6_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> $stable(out_frame));

    a_r7_tag_next: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && tag_seen |-> out_frame == FRAME_W'(prev_tag + 1'b1));

    a_r8_ready_when_room: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> fifo_level == LW'(FIFO_DEPTH));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(FIFO_DEPTH));

endmodule

bind ovl_frame_builder ovl_frame_builder_chk #(
    .K          (K),
    .FIFO_DEPTH (FIFO_DEPTH),
    .FRAME_W    (FRAME_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_frame  (out_frame),
    .out_index  (out_index),
    .fifo_level (fifo_level)
);

// File: tb/ovl_frame_builder_tb.sv
`timescale 1ns/1ps
module ovl_frame_builder_tb;
    localparam int K  = 8;
    localparam int M  = 6;
    localparam int DW = 16;
    localparam int FW = 4;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [FW-1:0] out_frame;
    logic [IW-1:0] out_index;

    logic          c_en = 1'b0;
    logic [DW-1:0] c_data = DW'(1);
    logic          c_ready;
    logic          c_valid;
    logic [DW-1:0] c_out;
    logic [FW-1:0] c_frame;
    logic [IW-1:0] c_index;

    int n_checks = 0;
    int n_fail   = 0;
    int sent     = 0;
    int c_sent   = 0;
    int mon_frame = 0;
    int mon_idx   = 0;
    int c_frames  = 0;
    int c_idx     = 0;
    bit saw_stall = 1'b0;
    bit done      = 1'b0;

    ovl_frame_builder #(.DATA_W(DW), .K(K), .M(M), .FIFO_DEPTH(4), .FRAME_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_frame(out_frame), .out_index(out_index));

    ovl_frame_builder #(.DATA_W(DW), .K(K), .M(K), .FIFO_DEPTH(4), .FRAME_W(FW)) u_dut_crit (
        .clk(clk), .rst_n(rst_n), .in_valid(c_en), .in_data(c_data), .in_ready(c_ready),
        .out_valid(c_valid), .out_data(c_out), .out_frame(c_frame), .out_index(c_index));

    function automatic void check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endfunction

    // expected beat value: sample n carries value n+1, never-received reads 0
    function automatic int exp_val(int kk, int mm, int f, int i);
        int sh = (f * mm) % kk;
        int j  = (i + sh) % kk;
        int n  = (f + 1) * mm - kk + j;
        return (n >= 0) ? ((n + 1) % 65536) : 0;
    endfunction

    // main instance monitor: R2, R3, R4, R6, R7, R8 (no loss/reorder)
    always @(negedge clk) begin
        if (rst_n && in_valid && !in_ready) saw_stall = 1'b1;
        if (rst_n && out_valid) begin
            if (out_index == 0)
                check(sent >= (mon_frame + 1) * M, "R2 samples accepted before frame", sent, (mon_frame + 1) * M);
            check(int'(out_index) == mon_idx, "R6 index order", out_index, mon_idx);
            check(int'(out_frame) == mon_frame % 16, "R7 frame tag", out_frame, mon_frame % 16);
            check(int'(out_data) == exp_val(K, M, mon_frame, mon_idx), "R4 rotated window data (R3)",
                  out_data, exp_val(K, M, mon_frame, mon_idx));
            if (mon_idx == K - 1) begin
                mon_idx = 0;
                mon_frame++;
            end else begin
                mon_idx++;
            end
        end
    end

    // critically sampled instance: R5
    always @(posedge clk) begin
        if (c_en && c_ready) begin
            c_sent <= c_sent + 1;
            c_data <= DW'(c_sent + 2);
        end
    end

    always @(negedge clk) begin
        if (rst_n && c_valid) begin
            check(int'(c_out) == exp_val(K, K, c_frames, c_idx), "R5 disjoint unrotated data",
                  c_out, exp_val(K, K, c_frames, c_idx));
            check(int'(c_index) == c_idx, "R5 index", c_index, c_idx);
            if (c_idx == K - 1) begin
                c_idx = 0;
                c_frames++;
            end else begin
                c_idx++;
            end
        end
    end

    task automatic feed(int count, int gap);
        for (int s = 0; s < count; s++) begin
            if (gap > 0) begin
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = DW'(sent + 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            sent++;
        end
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        check(out_frame == '0, "R1 frame tag after reset", out_frame, 0);
    endtask

    task automatic t_partial();
        feed(M - 1, 2);
        repeat (20) @(negedge clk);
        check(mon_frame == 0 && mon_idx == 0, "R2 no frame before M samples", mon_frame * K + mon_idx, 0);
        feed(1, 0);
        repeat (K + 6) @(negedge clk);
        check(mon_frame == 1, "R2 first frame after M samples (R1 zero fill)", mon_frame, 1);
    endtask

    task automatic t_stream();
        feed(30, 0);
        repeat (3 * K) @(negedge clk);
        check(mon_frame == sent / M, "R3 frames after continuous stream", mon_frame, sent / M);
        check(saw_stall == 1'b1, "R8 in_ready dropped under load", saw_stall, 1);
    endtask

    task automatic t_gapped_wrap();
        feed(72, 1);
        repeat (3 * K) @(negedge clk);
        check(mon_frame == sent / M, "R9 frames after gapped stream", mon_frame, sent / M);
        check(mon_frame > 16, "R7 tag wrapped", mon_frame, 17);
        check(mon_idx == 0, "R6 no partial frame", mon_idx, 0);
    endtask

    task automatic t_critical();
        @(negedge clk);
        c_en = 1'b1;
        repeat (120) @(negedge clk);
        c_en = 1'b0;
        repeat (3 * K) @(negedge clk);
        check(c_frames == c_sent / K, "R5 frame count", c_frames, c_sent / K);
        check(c_frames >= 5, "R5 frames produced", c_frames, 5);
    endtask

    initial begin
        t_reset();
        t_partial();
        t_stream();
        t_gapped_wrap();
        t_critical();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule